// File: doc/BRIEF.md
# Slow Oscillator Liveness Probe

This block tells whether an external 32.768 kHz time-base oscillator is running. The oscillator clocks a free-running counter outside this block. The counter value reaches this block already synchronised to the system clock.

A check starts on a request. The block first raises a count-force output, so that the counter runs whatever its normal gating is. It then takes a snapshot of the counter value and waits a fixed window that is longer than one oscillator period. After the window it takes a second snapshot and compares the two. Equal snapshots mean the oscillator is dead or unpowered. Different snapshots mean it is alive.

When the check ends, the block drops the force output, pulses a done flag and updates a held failure flag. The window is given as a time in nanoseconds and converted to system-clock cycles from the system clock frequency, with the result rounded up.

Top module: `osc_alive_probe`

## Requirements
- R1: After reset, `count_force_o`, `check_done_o` and `osc_fail_o` are all 0.
- R2: A request seen at a clock edge while idle drives `count_force_o` high from that edge on. It stays high until the edge that takes the second snapshot and is low while `check_done_o` is high.
- R3: The first snapshot is the value of `osc_count_i` at the first clock edge after the request edge, while the force output is already high. A counter change that lands before that edge is invisible to the comparison.
- R4: The second snapshot is taken WAIT_CYC+1 clock edges after the first one, where WAIT_CYC = ceil(SYS_CLK_HZ * WINDOW_NS / 1e9), and never less than 1. With the default 250 MHz clock and a 50000 ns window this gives 12500 cycles.
- R5: If the two snapshots are equal, `osc_fail_o` becomes 1. If they differ, it becomes 0.
- R6: `check_done_o` is high for exactly one cycle. That cycle follows the edge that takes the second snapshot, which is WAIT_CYC+2 edges after the request edge.
- R7: `osc_fail_o` changes only at the edge that raises `check_done_o`. Between checks it holds its value, whatever the counter does.
- R8: A request that arrives while a check is in progress is ignored. The running check keeps its timing and its result.
- R9: Only the two snapshots count. A counter that moves during the window but is back at its first value at the second snapshot is reported as failed.
- R10: A request held high starts a new check at the edge right after the done cycle begins, so the force output goes high again in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| check_req_i | input | 1 | Start a liveness check (sampled while idle) |
| osc_count_i | input | CNT_W | Oscillator-clocked counter value, already synchronised |
| count_force_o | output | 1 | Forces the external counter to count during a check |
| check_done_o | output | 1 | One-cycle pulse at the end of a check |
| osc_fail_o | output | 1 | 1 when the last check saw no counter change |

## Verification
The bench moves the counter exactly at the edges where the snapshots are taken. It changes the counter one edge before the first snapshot and in the snapshot edge itself, and also in the second snapshot edge and one edge after it. A design with the first snapshot off by one cycle, or a window one cycle short or long, reports the wrong verdict in one of those cases.

A counter that moves and then returns to its first value catches a design that records any movement instead of comparing the two snapshots. A request pulsed mid-check catches a design that restarts and so delays done. A request held high catches a design that stalls or skips the back-to-back restart. Counter activity while idle catches a failure flag that is not held between checks.

// File: rtl/osc_probe_pkg.sv
package osc_probe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SNAP1 = 2'd1,
    PH_WAIT  = 2'd2,
    PH_SNAP2 = 2'd3
  } probe_phase_e;

  // Window length in system cycles, rounded up, never below one.
  function automatic int window_cycles(input longint clk_hz, input longint win_ns);
    longint c;
    c = (clk_hz * win_ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/probe_window_timer.sv
module probe_window_timer #(
  parameter int CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int TW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [TW-1:0] RELOAD = TW'(CYCLES - 1);

  logic [TW-1:0] left_q, left_d;
  logic          left_en;

  always_comb begin
    left_en = 1'b0;
    left_d  = left_q;
    if (load_i) begin
      left_en = 1'b1;
      left_d  = RELOAD;
    end else if (run_i && (left_q != '0)) begin
      left_en = 1'b1;
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign expired_o = (left_q == '0);

  // The sequencer must leave the wait phase once the window is used up.
  assert_leave_on_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && expired_o) |=> !run_i);

endmodule

// File: rtl/probe_seq_fsm.sv
module probe_seq_fsm
  import osc_probe_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic         expired_i,
  output probe_phase_e phase_o,
  output logic         load_o,
  output logic         run_o,
  output logic         cap_o,
  output logic         cmp_o,
  output logic         force_o,
  output logic         done_o
);
  probe_phase_e phase_q, phase_d;
  logic         force_q, force_d;
  logic         done_q,  done_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (req_i) phase_d = PH_SNAP1;
      PH_SNAP1: phase_d = PH_WAIT;
      PH_WAIT:  if (expired_i) phase_d = PH_SNAP2;
      PH_SNAP2: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
    force_d = (phase_d != PH_IDLE);
    done_d  = (phase_q == PH_SNAP2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      force_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      force_q <= force_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign load_o  = (phase_q == PH_SNAP1);
  assign cap_o   = (phase_q == PH_SNAP1);
  assign run_o   = (phase_q == PH_WAIT);
  assign cmp_o   = (phase_q == PH_SNAP2);
  assign force_o = force_q;
  assign done_o  = done_q;

  assert_req_raises_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && req_i) |=> force_o);

  assert_force_before_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |-> force_o);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |=> (phase_q == PH_WAIT || phase_q == PH_SNAP2));

endmodule

// File: rtl/probe_snap_cmp.sv
module probe_snap_cmp #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_i,
  input  logic             cmp_i,
  output logic             fail_o
);
  logic [CNT_W-1:0] snap_q;
  logic             fail_q, fail_d;

  always_comb begin
    fail_d = fail_q;
    if (cmp_i) fail_d = (cnt_i == snap_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (cap_i) snap_q <= cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= fail_d;
  end

  assign fail_o = fail_q;

  assert_snap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(snap_q));

  assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_i |=> $stable(fail_o));

endmodule

// File: rtl/osc_alive_probe.sv
module osc_alive_probe
  import osc_probe_pkg::*;
#(
  parameter longint SYS_CLK_HZ = 250_000_000,
  parameter longint WINDOW_NS  = 50_000,
  parameter int     CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_req_i,
  input  logic [CNT_W-1:0] osc_count_i,
  output logic             count_force_o,
  output logic             check_done_o,
  output logic             osc_fail_o
);
  localparam int WAIT_CYC = window_cycles(SYS_CLK_HZ, WINDOW_NS);

  probe_phase_e phase;
  logic load, run, cap, cmp, expired;

  probe_seq_fsm u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (check_req_i),
    .expired_i (expired),
    .phase_o   (phase),
    .load_o    (load),
    .run_o     (run),
    .cap_o     (cap),
    .cmp_o     (cmp),
    .force_o   (count_force_o),
    .done_o    (check_done_o)
  );

  probe_window_timer #(.CYCLES(WAIT_CYC)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .run_i     (run),
    .expired_o (expired)
  );

  probe_snap_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (osc_count_i),
    .cap_i  (cap),
    .cmp_i  (cmp),
    .fail_o (osc_fail_o)
  );

  assert_force_low_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    check_done_o |-> !count_force_o);

  assert_done_follows_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp |=> check_done_o);

  assert_idle_phase_no_force_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !check_done_o && $past(phase) == PH_IDLE) |-> !count_force_o);

endmodule

// File: tb/sim_osc_alive_probe.sv
module sim_osc_alive_probe;
  localparam int CW = 16;
  localparam int W  = 20; // 80 ns at 250 MHz

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          req;
  logic [CW-1:0] cnt;
  logic          force_w, done_w, fail_w;
  int checks = 0, fails = 0;
  bit stop_mon = 1'b1;

  osc_alive_probe #(.SYS_CLK_HZ(250_000_000), .WINDOW_NS(80), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .check_req_i(req), .osc_count_i(cnt),
    .count_force_o(force_w), .check_done_o(done_w), .osc_fail_o(fail_w));

  // Behavioural reference model, stepped every rising edge.
  bit m_busy, m_force, m_done, m_fail;
  int m_age;
  int m_snap;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_force = 0; m_done = 0; m_fail = 0; m_age = 0; m_snap = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (req) begin m_busy = 1; m_age = 0; end
      end else begin
        m_age++;
        if (m_age == 1) m_snap = int'(cnt);
        if (m_age == W + 2) begin
          m_fail = (int'(cnt) == m_snap);
          m_done = 1; m_busy = 0;
        end
      end
      m_force = m_busy;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!stop_mon) begin
      chk("R2", "force vs model", int'(force_w), int'(m_force));
      chk("R6", "done vs model",  int'(done_w),  int'(m_done));
      chk("R5", "fail vs model",  int'(fail_w),  int'(m_fail));
    end
  end

  // One check: counter +1 at offset up, -1 at offset back, extra request at xreq.
  task automatic run_probe(input int up, input int back, input int xreq, input bit hold,
                           input int exp_fail, input string tag);
    int done_at = -1;
    for (int i = 0; i < W + 8; i++) begin
      @(negedge clk);
      if (done_w && done_at < 0) done_at = i;
      if (hold && i == W + 4) chk("R10", "force on restart", int'(force_w), 1);
      req = (i == 0) || (i == xreq) || hold;
      if (i == up)   cnt = cnt + 1'b1;
      if (i == back) cnt = cnt - 1'b1;
    end
    req = 1'b0;
    chk(tag, "done offset", done_at, W + 3);
    chk(tag, "verdict", int'(fail_w), exp_fail);
    repeat (W + 6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; cnt = 16'h1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    stop_mon = 1'b0;
    chk("R1", "force after reset", int'(force_w), 0);
    chk("R1", "done after reset",  int'(done_w),  0);
    chk("R1", "fail after reset",  int'(fail_w),  0);

    run_probe(-1, -1, -1, 0, 1, "R5");      // stuck counter
    repeat (5) @(negedge clk);
    cnt = cnt + 16'd7;                       // idle activity must not touch the flag
    repeat (5) @(negedge clk);
    chk("R7", "fail held while idle", int'(fail_w), 1);

    run_probe(5, -1, -1, 0, 0, "R5");       // live counter
    cnt = cnt + 16'd3;
    repeat (4) @(negedge clk);
    chk("R7", "alive held while idle", int'(fail_w), 0);

    run_probe(1, -1, -1, 0, 1, "R3");       // change before first snapshot
    run_probe(2, -1, -1, 0, 0, "R3");       // change in first snapshot edge
    run_probe(W + 2, -1, -1, 0, 0, "R4");   // change at second snapshot edge
    run_probe(W + 3, -1, -1, 0, 1, "R4");   // change just after window
    run_probe(5, 10, -1, 0, 1, "R9");       // moves and returns
    run_probe(5, -1, 8, 0, 0, "R8");        // mid-check request ignored
    run_probe(5, -1, -1, 1, 0, "R10");      // held request, back-to-back
    chk("R10", "second check verdict", int'(fail_w), 1);

    stop_mon = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule